// File: doc/BRIEF.md
# Write-Path CRC16 Sequencer

This block sits beside the byte engine of a serial-bus slave and produces the 16-bit check value that the slave sends back to the master after each byte written to data or status space. The value goes out before any programming step, so the master can compare it with its own value and decide whether to go on. The block never holds up the write because of a mismatch. The master alone makes that decision.

A start strobe opens a write command. On the first pass the check register is cleared. The command byte, the low address byte, the high address byte and the first data byte are then shifted through it. After each data byte the block increments its address. On every later pass it loads the new address into the check register in parallel and shifts only the next data byte through it. Data-memory writes and status-memory writes follow the same sequence, so the block does not need to know which space is being written.

Top module: `wr_crc_seq`

## Requirements
- R1: After reset `crc_valid` is 0 and `cur_addr` is 0. Bytes offered before the first `cmd_start` change no output.
- R2: On the first pass the check register starts at zero. Command, low address, high address and data bytes pass through it in that order. Each byte goes least significant bit first, with the reflected polynomial 0xA001 (x^16+x^15+x^2+1).
- R3: One cycle after a data byte is accepted, `crc_valid` is high for that cycle. `crc_lo` and `crc_hi` then hold bits 7:0 and 15:8 of the inverted register, and the low byte is the one sent first.
- R4: One cycle after the high address byte, `cur_addr` equals {high byte, low byte}.
- R5: Each data byte increments `cur_addr` by one, and 0xFFFF wraps to 0x0000. The new value is visible together with the `crc_valid` pulse.
- R6: On each later pass the register is loaded with the incremented address, without shifting. Only the new data byte is then shifted through it.
- R7: `cmd_start` aborts any pass and restarts first-pass behaviour with a cleared register. A byte offered in the same cycle is taken as the command byte, and it gives no `crc_valid`.
- R8: Consecutive data bytes, whether back to back or spaced, each produce their own check value. Nothing stops the sequence.
- R9: In a cycle with neither `byte_valid` nor `cmd_start`, `cur_addr` holds and no `crc_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start of a write command; restarts the sequence |
| byte_valid | input | 1 | `byte_data` holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| crc_valid | output | 1 | One-cycle strobe: check value ready |
| crc_lo | output | 8 | Inverted check value, low byte (sent first) |
| crc_hi | output | 8 | Inverted check value, high byte |
| cur_addr | output | 16 | Current write address |

## Verification
A restart and a data byte can arrive in the same cycle. The bench provokes this by asserting `cmd_start` together with a byte while the sequencer is in the data phase, and again midway through the address bytes. The case is judged correct when that byte produces no check strobe and the following pass matches a first-pass value computed from a cleared register. A restart given as a bare strobe, followed by the command as an ordinary byte, is also checked against the same first-pass value.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ALO,
    ST_AHI,
    ST_DATA
  } seq_state_e;

  typedef enum logic [2:0] {
    CO_HOLD,
    CO_CLEAR,
    CO_SEED,
    CO_SHIFT,
    CO_LOAD
  } crc_op_e;
endpackage

// File: rtl/wrs_crc_unit.sv
module wrs_crc_unit
  import wrs_pkg::*;
#(
  parameter int W      = 16,
  parameter int BYTE_W = 8,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rst,
  input  crc_op_e           op,
  input  logic [BYTE_W-1:0] din,
  input  logic [W-1:0]      load_val,
  output logic [W-1:0]      crc_next
);
  logic [W-1:0] crc_q;
  logic [W-1:0] chain [BYTE_W+1];

  // seeded shift starts from a cleared register
  assign chain[0] = (op == CO_SEED) ? '0 : crc_q;

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      logic fb;
      assign fb = chain[i][0] ^ din[i];
      assign chain[i+1] = (chain[i] >> 1) ^ (fb ? POLY : '0);
    end
  endgenerate

  assign crc_next = chain[BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else begin
      case (op)
        CO_CLEAR: crc_q <= '0;
        CO_SEED,
        CO_SHIFT: crc_q <= chain[BYTE_W];
        CO_LOAD:  crc_q <= load_val;
        default:  crc_q <= crc_q;
      endcase
    end
  end
endmodule

// File: rtl/wrs_addr_ctr.sv
module wrs_addr_ctr #(
  parameter int BYTE_W = 8,
  localparam int AW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              inc,
  input  logic [BYTE_W-1:0] din,
  output logic [AW-1:0]     addr,
  output logic [AW-1:0]     addr_inc
);
  logic [BYTE_W-1:0] lo_hold;

  assign addr_inc = addr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold <= '0;
      addr    <= '0;
    end else begin
      if (lo_we) lo_hold <= din;
      if (hi_we)     addr <= {din, lo_hold};
      else if (inc)  addr <= addr_inc;
    end
  end
endmodule

// File: rtl/wrs_fsm.sv
module wrs_fsm
  import wrs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_start,
  input  logic    byte_valid,
  output crc_op_e crc_op,
  output logic    lo_we,
  output logic    hi_we,
  output logic    addr_inc,
  output logic    emit
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    crc_op   = CO_HOLD;
    lo_we    = 1'b0;
    hi_we    = 1'b0;
    addr_inc = 1'b0;
    emit     = 1'b0;
    if (cmd_start) begin
      crc_op  = byte_valid ? CO_SEED : CO_CLEAR;
      state_d = byte_valid ? ST_ALO : ST_CMD;
    end else if (byte_valid) begin
      case (state_q)
        ST_CMD: begin
          crc_op  = CO_SHIFT;
          state_d = ST_ALO;
        end
        ST_ALO: begin
          crc_op  = CO_SHIFT;
          lo_we   = 1'b1;
          state_d = ST_AHI;
        end
        ST_AHI: begin
          crc_op  = CO_SHIFT;
          hi_we   = 1'b1;
          state_d = ST_DATA;
        end
        ST_DATA: begin
          crc_op   = CO_LOAD;
          emit     = 1'b1;
          addr_inc = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/wr_crc_seq.sv
module wr_crc_seq
  import wrs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] POLY = 16'hA001,
  localparam int WW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              crc_valid,
  output logic [BYTE_W-1:0] crc_lo,
  output logic [BYTE_W-1:0] crc_hi,
  output logic [WW-1:0]     cur_addr
);
  crc_op_e        crc_op;
  logic           lo_we, hi_we, addr_inc, emit;
  logic [WW-1:0]  next_addr;
  logic [WW-1:0]  crc_next;

  wrs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .byte_valid (byte_valid),
    .crc_op     (crc_op),
    .lo_we      (lo_we),
    .hi_we      (hi_we),
    .addr_inc   (addr_inc),
    .emit       (emit)
  );

  wrs_addr_ctr #(.BYTE_W(BYTE_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .inc      (addr_inc),
    .din      (byte_data),
    .addr     (cur_addr),
    .addr_inc (next_addr)
  );

  // later passes reload the register with the incremented address
  wrs_crc_unit #(.W(WW), .BYTE_W(BYTE_W), .POLY(POLY)) u_crc (
    .clk      (clk),
    .rst      (rst),
    .op       (crc_op),
    .din      (byte_data),
    .load_val (next_addr),
    .crc_next (crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_valid <= 1'b0;
      crc_lo    <= '0;
      crc_hi    <= '0;
    end else begin
      crc_valid <= emit;
      if (emit) {crc_hi, crc_lo} <= ~crc_next;
    end
  end
endmodule

// File: rtl/wr_crc_seq_chk.sv
module wr_crc_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_start,
  input logic          byte_valid,
  input logic          crc_valid,
  input logic [AW-1:0] cur_addr
);
  // R3
  strobe_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> ($past(byte_valid) && !$past(cmd_start)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> (cur_addr == AW'($past(cur_addr) + AW'(1))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !cmd_start) |=> ($stable(cur_addr) && !crc_valid));

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !crc_valid);
endmodule

bind wr_crc_seq wr_crc_seq_chk #(.AW(WW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_start  (cmd_start),
  .byte_valid (byte_valid),
  .crc_valid  (crc_valid),
  .cur_addr   (cur_addr)
);

// File: tb/sim_wr_crc_seq.sv
`timescale 1ns/1ps
module sim_wr_crc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        crc_valid;
  logic [7:0]  crc_lo, crc_hi;
  logic [15:0] cur_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] m_addr = 16'h0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  wr_crc_seq u0 (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .crc_valid(crc_valid), .crc_lo(crc_lo),
    .crc_hi(crc_hi), .cur_addr(cur_addr)
  );

  // reflected CRC-16, LSB first (R2)
  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic cs);
    @(negedge clk);
    cmd_start  = cs;
    byte_valid = 1'b1;
    byte_data  = b;
  endtask

  task automatic strobe_only();
    @(negedge clk);
    cmd_start  = 1'b1;
    byte_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_start  = 1'b0;
      byte_valid = 1'b0;
    end
  endtask

  // first pass: cleared register, cmd, lo, hi, data (R2, R4)
  task automatic first_pass(input logic [7:0] cmd, input logic [15:0] a,
                            input logic [7:0] d, input bit split, input string tag);
    logic [15:0] c;
    c = step(16'h0, cmd);
    c = step(c, a[7:0]);
    c = step(c, a[15:8]);
    c = step(c, d);
    if (split) begin
      strobe_only();
      put(cmd, 1'b0);
    end else begin
      put(cmd, 1'b1);
    end
    put(a[7:0], 1'b0);
    put(a[15:8], 1'b0);
    idle(1);
    check("R4 addr capture", {16'h0, cur_addr}, {16'h0, a});
    exp_q.push_back({16'h0, ~c} | {a + 16'd1, 16'h0});
    tag_q.push_back(tag);
    put(d, 1'b0);
    m_addr = a + 16'd1;
  endtask

  // later pass: load incremented address, shift data only (R6)
  task automatic next_pass(input logic [7:0] d, input string tag);
    logic [15:0] c;
    c = step(m_addr, d);
    exp_q.push_back({m_addr + 16'd1, ~c});
    tag_q.push_back(tag);
    put(d, 1'b0);
    m_addr = m_addr + 16'd1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && crc_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3/R7 unexpected strobe actual=%h%h expected=none", crc_hi, crc_lo);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " crc"}, {16'h0, crc_hi, crc_lo}, {16'h0, e[15:0]});
        check("R5 addr after data", {16'h0, cur_addr}, {16'h0, e[31:16]});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset valid", {31'h0, crc_valid}, 32'h0);
    check("R1 reset addr", {16'h0, cur_addr}, 32'h0);
    // R1 bytes before any command are ignored
    put(8'h0F, 1'b0); put(8'h34, 1'b0); put(8'h12, 1'b0); put(8'hAA, 1'b0);
    idle(2);
    check("R1 pre-command addr", {16'h0, cur_addr}, 32'h0);

    // R2 R3 first pass, then R6 R8 later passes back to back and spaced
    first_pass(8'h0F, 16'h1234, 8'hA5, 1'b0, "R2 first pass");
    next_pass(8'h5A, "R6 second pass");
    next_pass(8'hFF, "R8 back-to-back");
    idle(3);
    // R9 gaps hold address
    check("R9 idle hold addr", {16'h0, cur_addr}, {16'h0, m_addr});
    next_pass(8'h00, "R8 spaced");
    idle(2);

    // R7 restart with byte during data phase; R5 wrap
    first_pass(8'h55, 16'hFFFE, 8'h3C, 1'b0, "R7 restart in data");
    next_pass(8'hC3, "R5 to FFFF");
    next_pass(8'h81, "R5 wrap");
    idle(2);
    check("R5 wrapped addr", {16'h0, cur_addr}, 32'h0001);

    // R7 restart mid-address, then bare-strobe restart
    put(8'h0F, 1'b1); put(8'h77, 1'b0);
    first_pass(8'h0F, 16'h0100, 8'h42, 1'b0, "R7 restart mid-address");
    put(8'h0F, 1'b1); put(8'h10, 1'b0); put(8'h20, 1'b0);
    first_pass(8'h55, 16'h0020, 8'h99, 1'b1, "R7 bare strobe restart");
    next_pass(8'h18, "R6 status pass");
    idle(3);
    check("R8 all strobes seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule